// File: doc/BRIEF.md
# Ping-Pong Sample Buffer

This block collects a stream of 8-bit samples into two equal memory banks used in alternation. Each accepted sample is stored at the next address of the bank currently being filled. When the sample at the last address lands, filling moves on to address 0 of the other bank with no idle cycle. The bank that just completed becomes the one the host reads, and an interrupt is raised. One interrupt is raised per completed bank, not per sample.

The host reads the completed bank through its own address and data port while the producer keeps writing into the other bank. The interrupt stays high until the host acknowledges it. If a further bank completes while the interrupt is still unacknowledged, a sticky overrun flag is set, and it stays set until the host clears it.

Top module: `pingpong_sample_buf`

## Requirements
- R1: After reset, `irq`, `overrun` and `ready_bank` are all 0.
- R2: A cycle with `s_valid` low stores nothing and does not advance the write position, whatever value `s_data` carries.
- R3: `irq` becomes 1 at the clock edge that accepts the 512th sample of a bank (counted from the start of that bank), and not before.
- R4: On each bank completion `ready_bank` takes the number of the bank just completed. Banks complete in the order 0, 1, 0, 1, and so on, starting with bank 0 after reset.
- R5: `host_data` shows the byte at `host_addr` of bank `ready_bank` one clock after the address is presented. Address k holds the k-th sample (from 0) written into that bank.
- R6: The sample accepted right after a bank completes goes to address 0 of the other bank. Back-to-back samples across a switch are all kept.
- R7: Once set, `irq` stays 1 until a cycle with `irq_ack` = 1, after which it reads 0.
- R8: If a bank completes while `irq` is 1 and `irq_ack` is low in that cycle, `overrun` becomes 1. It then stays 1, even across an acknowledge, until a cycle with `overrun_clr` = 1.
- R9: If `irq_ack` arrives in the same cycle a bank completes, `irq` remains 1 and `overrun` is not set.
- R10: Writes into the filling bank leave the contents of the ready bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample strobe; a sample is taken in each cycle it is high |
| s_data | input | 8 | Sample value |
| host_addr | input | 9 | Host read address within the ready bank |
| host_data | output | 8 | Host read data, one cycle after the address |
| ready_bank | output | 1 | Bank most recently completed, available to the host |
| irq | output | 1 | Bank-complete interrupt, level, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| overrun | output | 1 | Sticky flag: a bank completed before the previous interrupt was acknowledged |
| overrun_clr | input | 1 | Clears the overrun flag |

## Verification
The assertions assume that every input is synchronous to `clk` and never unknown after reset, and that `irq_ack` and `overrun_clr` are single-cycle pulses whose effect is read from the registered outputs one edge later. They also assume the host reads only `ready_bank`, never the bank being filled. The bench drives all inputs on the falling edge and clears the strobes shortly after the rising edge, so each pulse covers exactly one sampling edge. Reads go only to the completed bank, and acknowledge pulses are placed either well apart from a bank completion or deliberately on the completing edge.

// File: rtl/pingpong_sample_buf.sv
module pingpong_sample_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic [AW-1:0] host_addr,
  output logic [DW-1:0] host_data,
  output logic          ready_bank,
  output logic          irq,
  input  logic          irq_ack,
  output logic          overrun,
  input  logic          overrun_clr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [2*DEPTH];
  logic [AW-1:0] wr_ptr;
  logic          wr_bank;
  logic          fill;

  assign fill = s_valid && (wr_ptr == LAST);

  always_ff @(posedge clk) begin
    if (s_valid) mem[{wr_bank, wr_ptr}] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_data <= '0;
    else        host_data <= mem[{ready_bank, host_addr}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      wr_bank    <= 1'b0;
      ready_bank <= 1'b0;
    end else if (s_valid) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (fill) begin
        wr_bank    <= ~wr_bank;
        ready_bank <= wr_bank;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (fill)         irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (fill && irq && !irq_ack) overrun <= 1'b1;
      else if (overrun_clr)        overrun <= 1'b0;
    end
  end

  a_r3_irq_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> irq);

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (wr_ptr == '0));

  a_r4_ready_is_other: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (ready_bank != wr_bank));

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !fill) |=> !irq);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  a_r2_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(wr_ptr) && $stable(wr_bank));

endmodule

// File: tb/pingpong_sample_buf_tb.sv
module pingpong_sample_buf_tb_top;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic [8:0] host_addr = '0;
  logic [7:0] host_data;
  logic       ready_bank, irq, overrun;
  logic       irq_ack = 1'b0;
  logic       overrun_clr = 1'b0;

  int total = 0;
  int bad = 0;
  int seq = 0;
  int m_bank = 0;
  int m_ptr = 0;
  logic [7:0] exp_mem [2][DEPTH];

  always #10 clk = ~clk;

  pingpong_sample_buf dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .host_addr(host_addr), .host_data(host_data), .ready_bank(ready_bank),
    .irq(irq), .irq_ack(irq_ack), .overrun(overrun), .overrun_clr(overrun_clr)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(bit ack);
    logic [7:0] v;
    v = 8'(seq * 37 + 11);
    seq++;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = v;
    irq_ack = ack;
    exp_mem[m_bank][m_ptr] = v;
    m_ptr++;
    if (m_ptr == DEPTH) begin
      m_ptr = 0;
      m_bank ^= 1;
    end
    @(posedge clk);
    #2;
    s_valid = 1'b0;
    irq_ack = 1'b0;
    s_data  = 8'hA5;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_data = 8'(i * 91 + 3);
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(posedge clk);
    #2;
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ovr_clr();
    @(negedge clk);
    overrun_clr = 1'b1;
    @(posedge clk);
    #2;
    overrun_clr = 1'b0;
  endtask

  task automatic read_bank(int b, string req);
    for (int a = 0; a <= DEPTH; a++) begin
      @(negedge clk);
      if (a > 0) chk(req, host_data, exp_mem[b][a-1]);
      if (a < DEPTH) host_addr = 9'(a);
    end
  endtask

  task automatic t_reset();
    idle(1);
    chk("R1 irq", irq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 ready_bank", ready_bank, 0);
  endtask

  task automatic t_first_fill();
    for (int i = 0; i < DEPTH - 1; i++) begin
      push(1'b0);
      if (i % 50 == 0) idle(2);
    end
    idle(3);
    chk("R2 R3 no irq before last sample", irq, 0);
    push(1'b0);
    @(negedge clk);
    chk("R3 irq after 512th sample", irq, 1);
    chk("R4 first ready bank", ready_bank, 0);
    chk("R8 no overrun", overrun, 0);
    read_bank(0, "R5 R2 bank0 data");
  endtask

  task automatic t_ack();
    idle(5);
    chk("R7 irq held", irq, 1);
    pulse_ack();
    @(negedge clk);
    chk("R7 irq cleared by ack", irq, 0);
  endtask

  task automatic t_second_fill();
    for (int i = 0; i < DEPTH / 2; i++) push(1'b0);
    read_bank(0, "R10 ready bank untouched");
    for (int i = 0; i < DEPTH / 2; i++) push(1'b0);
    @(negedge clk);
    chk("R3 irq second fill", irq, 1);
    chk("R4 second ready bank", ready_bank, 1);
    chk("R8 no overrun after acked fill", overrun, 0);
    read_bank(1, "R6 bank1 gapless data");
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(1'b0);
    @(negedge clk);
    chk("R8 overrun set", overrun, 1);
    chk("R4 third ready bank", ready_bank, 0);
    idle(4);
    chk("R8 overrun sticky", overrun, 1);
    pulse_ack();
    @(negedge clk);
    chk("R8 overrun survives ack", overrun, 1);
    chk("R7 irq cleared", irq, 0);
    pulse_ovr_clr();
    @(negedge clk);
    chk("R8 overrun cleared", overrun, 0);
    read_bank(0, "R6 bank0 refill data");
  endtask

  task automatic t_ack_coincide();
    for (int i = 0; i < DEPTH; i++) push(1'b0);
    @(negedge clk);
    chk("R3 irq fourth fill", irq, 1);
    chk("R4 fourth ready bank", ready_bank, 1);
    for (int i = 0; i < DEPTH - 1; i++) push(1'b0);
    push(1'b1);
    @(negedge clk);
    chk("R9 irq stays with same-cycle ack", irq, 1);
    chk("R9 no overrun with same-cycle ack", overrun, 0);
    chk("R4 fifth ready bank", ready_bank, 0);
    read_bank(0, "R5 bank0 fifth fill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_fill();
    t_ack();
    t_second_fill();
    t_overrun();
    t_ack_coincide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule